// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial frames from a single line and returns each character as a parallel word. The line is sampled on a 16x oversampling tick, and every bit is decided by a vote over three samples taken around its centre. A frame is one start bit, eight or nine data bits sent least significant bit first, and one stop bit. Either the last data bit carries a parity bit, with even or odd parity, or it carries plain data. The receiver reports a framing error when a stop bit reads low. It reports an overrun when a new character arrives before the previous one has been acknowledged. It also raises a flag once for each idle period it sees on the line.

The receiver is built for multidrop links, where many stations share one line. Software puts it to sleep with a one-cycle request. While it sleeps, it keeps decoding frames but updates none of its result flags. Hardware wakes it in one of two ways, chosen by a control input. In the first, it wakes when it detects an idle line. In the second, it wakes on an address-mark frame, which is a frame whose last data bit is 1. The address-mark frame is delivered as data. For self-test, a loop select replaces the external pin with an internal transmit line.

Top module: `serial_rx_wake`

## Requirements
- R1: After reset, rx_ready, par_err, frame_err, overrun, idle_seen and asleep are all 0.
- R2: With wide_frame=0, a frame is a start bit, 8 data bits sent LSB first and a stop bit. The received bits appear on rx_data[7:0] with rx_data[8]=0, and rx_ready is set. With wide_frame=1, 9 data bits fill rx_data[8:0].
- R3: With par_en=1, the last data bit is the parity bit and stays in rx_data. par_err is set when the XOR of all received data bits differs from par_odd (0 selects even parity, 1 selects odd parity). With par_en=0, par_err stays 0.
- R4: A stop bit that resolves to 0 sets frame_err together with rx_ready, and the data is still delivered.
- R5: A frame that completes while rx_ready=1 sets overrun and leaves rx_data unchanged. rd_ack clears all five result flags. If rd_ack falls in the same cycle as a frame completion, the new frame is delivered and overrun stays 0.
- R6: Each bit is resolved by a 2-of-3 majority vote over oversample positions 7, 8 and 9, counted from the detected falling edge. A start bit that resolves to 1 is dropped as noise, and the receiver goes back to hunting for a start bit.
- R7: An idle line is detected after 16x(frame bits) consecutive ticks at 1, where the frame is 10 bits for wide_frame=0 and 11 bits for wide_frame=1. With idle_long=0, the count runs on any 1, including the ones inside a character.
- R8: With idle_long=1, idle counting runs only while the receiver is between frames, which begins at the stop-bit vote.
- R9: idle_seen is set at most once per idle period. Detection is re-armed only by a start bit that is accepted after voting.
- R10: sleep_set sets asleep. While asleep, frames leave rx_ready and the error flags untouched, and idle detection does not set idle_seen. With wake_addr=0, an idle detection clears asleep.
- R11: With wake_addr=1, only a frame whose last data bit (bit 7 when wide_frame=0, bit 8 when wide_frame=1) is 1 clears asleep. That frame is delivered as data.
- R12: With loop_sel=1, the receiver decodes loop_tx and ignores rx_pin.
- R13: Taking rx_en low aborts any frame in progress. No result is produced for that frame, and reception resumes from the hunting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| rx_pin | input | 1 | External serial line |
| loop_tx | input | 1 | Internal transmit line used in loop mode |
| rx_en | input | 1 | Receiver enable |
| loop_sel | input | 1 | 1 selects loop_tx as the receive line |
| wide_frame | input | 1 | 0: 8 data bits, 1: 9 data bits |
| par_en | input | 1 | Parity checking enable |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| idle_long | input | 1 | 0 count idle from any 1, 1 count only between frames |
| wake_addr | input | 1 | 0 wake on idle line, 1 wake on address mark |
| sleep_set | input | 1 | One-cycle request to enter sleep |
| rd_ack | input | 1 | Clears the result flags |
| rx_data | output | 9 | Received data bits, first bit in bit 0 |
| rx_ready | output | 1 | A character is waiting |
| par_err | output | 1 | Parity error on the held character |
| frame_err | output | 1 | Stop bit read as 0 |
| overrun | output | 1 | Character lost because rx_ready was set |
| idle_seen | output | 1 | Idle line detected |
| asleep | output | 1 | Receiver wakeup flag |

## Verification
Two events can land on the same clock edge: a frame completing and the acknowledge clearing the previous character. If the acknowledge were handled with the wrong priority, a correct frame would turn into an overrun or be lost. The bench first times one frame to find the cycle in which rx_ready rises. It then sends a second, identical frame while the first is still unacknowledged, and pulses rd_ack exactly at that cycle. It passes only if the second character is held, rx_ready is set and overrun stays clear. The checker also requires that any overrun leaves the held data unchanged.

// File: rtl/srw_pkg.sv
package srw_pkg;

  typedef enum logic [1:0] {
    RX_HUNT,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/srw_line_in.sv
module srw_line_in (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic loop_line,
  input  logic use_loop,
  output logic line_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], use_loop ? loop_line : pin};
  end

  assign line_o = sync_q[1];

endmodule

// File: rtl/srw_framer.sv
module srw_framer
  import srw_pkg::*;
#(
  parameter int OS       = 16,
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                en,
  input  logic                line,
  input  logic                wide,
  output logic                done_o,
  output logic                stop_ok_o,
  output logic                start_ok_o,
  output logic                hunting_o,
  output logic [DATA_MAX-1:0] bits_o
);

  localparam int CW = $clog2(OS);
  localparam int BW = $clog2(DATA_MAX);
  localparam logic [CW-1:0] POS_A   = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] POS_B   = CW'(OS / 2);
  localparam logic [CW-1:0] POS_C   = CW'(OS / 2 + 1);
  localparam logic [CW-1:0] POS_END = CW'(OS - 1);
  localparam logic [BW-1:0] LAST_W  = BW'(DATA_MAX - 1);
  localparam logic [BW-1:0] LAST_N  = BW'(DATA_MAX - 2);

  rx_state_e      st_q;
  logic [CW-1:0]  cnt_q;
  logic [BW-1:0]  bitn_q;
  logic           s_a_q, s_b_q;
  logic           vote;
  logic [BW-1:0]  last_idx;

  assign vote      = maj3(s_a_q, s_b_q, line);
  assign last_idx  = wide ? LAST_W : LAST_N;
  assign hunting_o = (st_q == RX_HUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= RX_HUNT;
      cnt_q      <= '0;
      bitn_q     <= '0;
      s_a_q      <= 1'b1;
      s_b_q      <= 1'b1;
      bits_o     <= '0;
      done_o     <= 1'b0;
      stop_ok_o  <= 1'b0;
      start_ok_o <= 1'b0;
    end else begin
      done_o     <= 1'b0;
      start_ok_o <= 1'b0;
      if (!en) begin
        st_q  <= RX_HUNT;
        cnt_q <= '0;
      end else if (tick) begin
        if (st_q == RX_HUNT) begin
          if (!line) begin
            st_q   <= RX_START;
            cnt_q  <= CW'(1);
            bits_o <= '0;
          end
        end else begin
          cnt_q <= (cnt_q == POS_END) ? '0 : cnt_q + 1'b1;
          if (cnt_q == POS_A) s_a_q <= line;
          if (cnt_q == POS_B) s_b_q <= line;
          if (cnt_q == POS_C) begin
            case (st_q)
              RX_START: begin
                if (vote) st_q <= RX_HUNT;
                else      start_ok_o <= 1'b1;
              end
              RX_DATA: bits_o[bitn_q] <= vote;
              RX_STOP: begin
                done_o    <= 1'b1;
                stop_ok_o <= vote;
                st_q      <= RX_HUNT;
              end
              default: st_q <= RX_HUNT;
            endcase
          end
          if (cnt_q == POS_END) begin
            case (st_q)
              RX_START: begin
                st_q   <= RX_DATA;
                bitn_q <= '0;
              end
              RX_DATA: begin
                if (bitn_q == last_idx) st_q <= RX_STOP;
                else                    bitn_q <= bitn_q + 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/srw_idle_mon.sv
module srw_idle_mon #(
  parameter int OS       = 16,
  parameter int DATA_MAX = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en,
  input  logic line,
  input  logic long_mode,
  input  logic hunting,
  input  logic wide,
  input  logic rearm,
  output logic idle_ev_o
);

  localparam int LIM_MAX = (DATA_MAX + 2) * OS;
  localparam int IW      = $clog2(LIM_MAX + 1);
  localparam logic [IW-1:0] LIM_W = IW'(LIM_MAX);
  localparam logic [IW-1:0] LIM_N = IW'((DATA_MAX + 1) * OS);

  logic [IW-1:0] run_q;
  logic [IW-1:0] lim;
  logic          armed_q;

  assign lim = wide ? LIM_W : LIM_N;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      armed_q   <= 1'b0;
      idle_ev_o <= 1'b0;
    end else begin
      idle_ev_o <= 1'b0;
      if (!en) begin
        run_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        if (tick) begin
          if (!line || (long_mode && !hunting)) begin
            run_q <= '0;
          end else if (run_q < lim) begin
            run_q <= run_q + 1'b1;
            if (run_q == lim - 1'b1 && armed_q) begin
              idle_ev_o <= 1'b1;
              armed_q   <= 1'b0;
            end
          end
        end
        if (rearm) armed_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_rx_wake.sv
module serial_rx_wake #(
  parameter int OS       = 16,
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                os_tick,
  input  logic                rx_pin,
  input  logic                loop_tx,
  input  logic                rx_en,
  input  logic                loop_sel,
  input  logic                wide_frame,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                idle_long,
  input  logic                wake_addr,
  input  logic                sleep_set,
  input  logic                rd_ack,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_ready,
  output logic                par_err,
  output logic                frame_err,
  output logic                overrun,
  output logic                idle_seen,
  output logic                asleep
);

  logic                line;
  logic                done, stop_ok, start_ok, hunting, idle_ev;
  logic [DATA_MAX-1:0] bits;
  logic [DATA_MAX-1:0] narrow_mask, mask;
  logic                last_bit, par_bad, wake_hit, idle_wake, deliver;

  // Mask of the data bits used in a narrow frame (all but the top bit).
  for (genvar gi = 0; gi < DATA_MAX; gi++) begin : g_mask
    assign narrow_mask[gi] = (gi < DATA_MAX - 1);
  end

  srw_line_in line_i (
    .clk      (clk),
    .rst      (rst),
    .pin      (rx_pin),
    .loop_line(loop_tx),
    .use_loop (loop_sel),
    .line_o   (line)
  );

  srw_framer #(.OS(OS), .DATA_MAX(DATA_MAX)) framer_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (os_tick),
    .en        (rx_en),
    .line      (line),
    .wide      (wide_frame),
    .done_o    (done),
    .stop_ok_o (stop_ok),
    .start_ok_o(start_ok),
    .hunting_o (hunting),
    .bits_o    (bits)
  );

  srw_idle_mon #(.OS(OS), .DATA_MAX(DATA_MAX)) idle_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (os_tick),
    .en       (rx_en),
    .line     (line),
    .long_mode(idle_long),
    .hunting  (hunting),
    .wide     (wide_frame),
    .rearm    (start_ok),
    .idle_ev_o(idle_ev)
  );

  assign mask      = wide_frame ? '1 : narrow_mask;
  assign last_bit  = wide_frame ? bits[DATA_MAX-1] : bits[DATA_MAX-2];
  assign par_bad   = par_en && ((^(bits & mask)) != par_odd);
  assign wake_hit  = asleep && done && wake_addr && last_bit;
  assign idle_wake = asleep && idle_ev && !wake_addr;
  assign deliver   = done && (!asleep || wake_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_ready  <= 1'b0;
      par_err   <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
      idle_seen <= 1'b0;
      asleep    <= 1'b0;
    end else begin
      if (rd_ack) begin
        rx_ready  <= 1'b0;
        par_err   <= 1'b0;
        frame_err <= 1'b0;
        overrun   <= 1'b0;
        idle_seen <= 1'b0;
      end
      if (deliver) begin
        if (rx_ready && !rd_ack) begin
          overrun <= 1'b1;
        end else begin
          rx_data   <= bits & mask;
          rx_ready  <= 1'b1;
          par_err   <= par_bad;
          frame_err <= !stop_ok;
        end
      end
      if (idle_ev && !asleep) idle_seen <= 1'b1;
      if (sleep_set)                  asleep <= 1'b1;
      else if (wake_hit || idle_wake) asleep <= 1'b0;
    end
  end

endmodule

// File: rtl/srw_checker.sv
module srw_checker #(
  parameter int DATA_MAX = 9
) (
  input logic                clk,
  input logic                rst,
  input logic                rx_en,
  input logic                wake_addr,
  input logic                rx_ready,
  input logic                par_err,
  input logic                overrun,
  input logic                idle_seen,
  input logic                asleep,
  input logic [DATA_MAX-1:0] rx_data
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!rx_ready && !asleep && !overrun && !idle_seen && !par_err));

  a_r5_overrun_keeps_data: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> ($stable(rx_data) && rx_ready));

  a_r3_perr_with_data: assert property (@(posedge clk) disable iff (rst)
    $rose(par_err) |-> rx_ready);

  a_r10_no_idle_flag_asleep: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_seen) |-> !$past(asleep));

  a_r11_addr_wake_delivers: assert property (@(posedge clk) disable iff (rst)
    ($fell(asleep) && $past(wake_addr) && !$past(rx_ready)) |-> rx_ready);

  a_r13_disabled_no_frame: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !$past(rx_en)) |=> !$rose(rx_ready));

endmodule

bind serial_rx_wake srw_checker #(.DATA_MAX(DATA_MAX)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rx_en    (rx_en),
  .wake_addr(wake_addr),
  .rx_ready (rx_ready),
  .par_err  (par_err),
  .overrun  (overrun),
  .idle_seen(idle_seen),
  .asleep   (asleep),
  .rx_data  (rx_data)
);

// File: tb/serial_rx_wake_tb_top.sv
module serial_rx_wake_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_q = 1'b0;
  logic drv = 1'b1;
  logic bench_loop = 1'b0;
  logic rx_en = 1'b0, loop_sel = 1'b0, wide_frame = 1'b0, par_en = 1'b0;
  logic par_odd = 1'b0, idle_long = 1'b0, wake_addr = 1'b0;
  logic sleep_set = 1'b0, rd_ack = 1'b0;
  logic rx_pin, loop_tx;
  logic [8:0] rx_data;
  logic rx_ready, par_err, frame_err, overrun, idle_seen, asleep;
  int n_checks = 0;
  int n_err = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tick_q <= ~tick_q;

  assign rx_pin  = bench_loop ? 1'b0 : drv;
  assign loop_tx = bench_loop ? drv : 1'b0;

  serial_rx_wake dut_i (
    .clk(clk), .rst(rst), .os_tick(tick_q), .rx_pin(rx_pin), .loop_tx(loop_tx),
    .rx_en(rx_en), .loop_sel(loop_sel), .wide_frame(wide_frame), .par_en(par_en),
    .par_odd(par_odd), .idle_long(idle_long), .wake_addr(wake_addr),
    .sleep_set(sleep_set), .rd_ack(rd_ack), .rx_data(rx_data), .rx_ready(rx_ready),
    .par_err(par_err), .frame_err(frame_err), .overrun(overrun),
    .idle_seen(idle_seen), .asleep(asleep)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    drv = v;
    wait_clk(32);
  endtask

  task automatic send_head(input logic [8:0] bits, input int nd);
    send_bit(1'b0);
    for (int b = 0; b < nd; b++) send_bit(bits[b]);
  endtask

  task automatic send_frame(input logic [8:0] bits, input int nd, input logic stop_v);
    send_head(bits, nd);
    send_bit(stop_v);
    drv = 1'b1;
  endtask

  task automatic ack();
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
  endtask

  task automatic go_sleep();
    @(negedge clk) sleep_set = 1'b1;
    @(negedge clk) sleep_set = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int n_edge;
    logic [7:0] v;
    logic corrupt, pbit;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    // R1: reset state
    chk({rx_ready, par_err, frame_err, overrun, idle_seen, asleep} == 6'b0,
        "R1 flags after reset", {rx_ready, par_err, frame_err, overrun, idle_seen, asleep}, 0);
    rx_en = 1'b1;
    wait_clk(40);

    // R2: 8-bit frames, sweep with every bit toggling
    for (int i = 0; i < 128; i++) begin
      v = {7'(i), ^(7'(i))};
      send_frame({1'b0, v}, 8, 1'b1);
      chk(rx_ready && rx_data == {1'b0, v} && !par_err && !frame_err,
          "R2 narrow frame data", int'(rx_data), int'(v));
      ack();
    end

    // R3: 9-bit frames with parity, both types, some corrupted
    wide_frame = 1'b1;
    par_en = 1'b1;
    for (int t = 0; t < 2; t++) begin
      par_odd = t[0];
      for (int i = 0; i < 64; i++) begin
        v = 8'(i * 4 + t + 1) ^ 8'(i << 2);
        corrupt = (i % 3 == 0);
        pbit = (^v) ^ par_odd ^ corrupt;
        send_frame({pbit, v}, 9, 1'b1);
        chk(rx_ready && rx_data == {pbit, v}, "R3 wide data with parity bit",
            int'(rx_data), int'({pbit, v}));
        chk(par_err == corrupt, "R3 parity error", par_err, corrupt);
        ack();
      end
    end
    // R3: parity disabled never flags
    par_en = 1'b0;
    send_frame(9'h101, 9, 1'b1);
    chk(rx_ready && rx_data == 9'h101 && !par_err, "R3 parity off", int'(par_err), 0);
    ack();
    wide_frame = 1'b0;
    par_odd = 1'b0;

    // R4: framing error
    send_frame(9'h06E, 8, 1'b0);
    wait_clk(40);
    chk(frame_err && rx_ready && rx_data == 9'h06E, "R4 framing error", frame_err, 1);
    ack();
    wait_clk(40);

    // R5: overrun keeps first data
    send_frame(9'h011, 8, 1'b1);
    send_frame(9'h022, 8, 1'b1);
    chk(overrun && rx_ready && rx_data == 9'h011, "R5 overrun keeps data", int'(rx_data), 'h11);
    ack();
    chk({rx_ready, par_err, frame_err, overrun, idle_seen} == 5'b0, "R5 ack clears flags",
        {rx_ready, par_err, frame_err, overrun, idle_seen}, 0);

    // R5: ack in the completion cycle
    n_edge = 0;
    send_head(9'h031, 8);
    drv = 1'b1;
    for (int i = 1; i <= 32; i++) begin
      @(negedge clk);
      if (n_edge == 0 && rx_ready) n_edge = i;
    end
    chk(n_edge >= 2, "R5 completion timed", n_edge, 2);
    send_head(9'h032, 8);
    drv = 1'b1;
    for (int i = 1; i <= 32; i++) begin
      @(negedge clk);
      if (i == n_edge - 1) rd_ack = 1'b1;
      if (i == n_edge) rd_ack = 1'b0;
    end
    chk(rx_ready && !overrun && rx_data == 9'h032, "R5 ack with completion",
        int'(rx_data), 'h32);
    ack();

    // R6: short low glitch is noise
    drv = 1'b0;
    wait_clk(8);
    drv = 1'b1;
    wait_clk(340);
    chk(!rx_ready && !frame_err, "R6 glitch rejected", rx_ready, 0);
    send_frame(9'h04D, 8, 1'b1);
    chk(rx_ready && rx_data == 9'h04D, "R6 frame after glitch", int'(rx_data), 'h4D);
    ack();

    // R7: short idle counts ones inside the character
    idle_long = 1'b0;
    ack();
    send_frame(9'h0FF, 8, 1'b1);
    wait_clk(130);
    chk(idle_seen, "R7 short idle detected", idle_seen, 1);
    ack();
    // R8: long idle counts only after the stop bit
    idle_long = 1'b1;
    send_frame(9'h0FF, 8, 1'b1);
    wait_clk(130);
    chk(!idle_seen, "R8 long idle not yet", idle_seen, 0);
    wait_clk(250);
    chk(idle_seen, "R8 long idle detected", idle_seen, 1);
    ack();
    // R9: no second flag in the same idle period
    wait_clk(800);
    chk(!idle_seen, "R9 idle flagged once", idle_seen, 0);
    send_frame(9'h000, 8, 1'b1);
    wait_clk(700);
    chk(idle_seen, "R9 rearmed by start", idle_seen, 1);
    ack();
    idle_long = 1'b0;

    // R10: sleep, woken by idle line
    wake_addr = 1'b0;
    go_sleep();
    chk(asleep, "R10 sleep set", asleep, 1);
    send_frame(9'h03C, 8, 1'b1);
    chk(!rx_ready && asleep, "R10 frame ignored asleep", rx_ready, 0);
    wait_clk(400);
    chk(!asleep && !idle_seen, "R10 idle wake without flag", {asleep, idle_seen}, 0);
    send_frame(9'h05A, 8, 1'b1);
    chk(rx_ready && rx_data == 9'h05A, "R10 frame after wake", int'(rx_data), 'h5A);
    ack();

    // R11: sleep, woken by address mark (bit 7 set in 8-bit frames)
    wake_addr = 1'b1;
    go_sleep();
    send_frame(9'h012, 8, 1'b1);
    chk(!rx_ready && asleep, "R11 non-address ignored", {rx_ready, asleep}, 1);
    wait_clk(800);
    chk(asleep && !idle_seen, "R11 idle does not wake", {asleep, idle_seen}, 2);
    send_frame(9'h085, 8, 1'b1);
    chk(rx_ready && rx_data == 9'h085 && !asleep, "R11 address frame delivered",
        int'(rx_data), 'h85);
    ack();
    wake_addr = 1'b0;

    // R12: loop mode uses the internal line
    @(negedge clk);
    bench_loop = 1'b1;
    loop_sel = 1'b1;
    wait_clk(40);
    send_frame(9'h0A7, 8, 1'b1);
    chk(rx_ready && rx_data == 9'h0A7, "R12 loop data", int'(rx_data), 'hA7);
    ack();
    bench_loop = 1'b0;
    loop_sel = 1'b0;
    wait_clk(40);

    // R13: disabling aborts a frame
    send_head(9'h000, 3);
    rx_en = 1'b0;
    wait_clk(10);
    drv = 1'b1;
    rx_en = 1'b1;
    wait_clk(400);
    chk(!rx_ready && !frame_err, "R13 aborted frame dropped", rx_ready, 0);
    send_frame(9'h0C3, 8, 1'b1);
    chk(rx_ready && rx_data == 9'h0C3, "R13 reception resumes", int'(rx_data), 'hC3);
    ack();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule